// File: doc/BRIEF.md
# Indexed Block-Access Configuration Target on I2C

This block is an I2C target that holds a bank of byte-wide configuration registers for the rest of the chip. The bus lines are brought into the system clock domain, synchronized and glitch-filtered. The block then decodes START and STOP conditions and runs a byte-level state machine. SDA is driven open-drain through a pull-low enable.

Each transfer names a starting register and a byte count. In a write, the host sends the target's write address, a start index and a count, and then that many data bytes. The block stores them at consecutive registers. In a read, the host sends the write address and the index, then issues a repeated START with the read address. The block first returns the contents of its count register and then streams registers from the index upward until the host answers with a NACK. A few registers or fields are fixed identifiers or copies of strap pins, and writes do not change them. The register contents are presented in parallel on one flat output bus.

Top module: `i2cx_slave`

## Requirements
- R1: Address byte 0xD2 (write) and 0xD3 (read) are ACKed. Any other address byte is NACKed, and the following bytes are neither ACKed nor stored until the next START.
- R2: A write carries, after 0xD2, an index byte N and a count byte X. The next X data bytes are stored at registers N, N+1, and onward, and every byte is ACKed.
- R3: Data bytes sent after the count X is used up are ACKed but do not change any register.
- R4: After a repeated START with 0xD3, the first byte returned is register 8. The bytes after it are the registers from index N upward, sent MSB first.
- R5: A NACK from the host after a read byte ends the stream, and the block releases SDA.
- R6: Register 8 resets to 0x0F and is fully writable. Its value is the count byte that later reads return first.
- R7: Register 7 always reads 0x22. Register 6 reads as {REV_ID, 4'b0001}, with REV_ID defaulting to 0. Writes to either register have no effect.
- R8: Bits 3:0 of register 1 hold the value of strap_i captured at the first clock after reset and ignore later changes of strap_i and any writes. Bits 7:4 of register 1 are writable.
- R9: An index of 24 or more reads as 0x00 and ignores writes, and those bytes are still ACKed.
- R10: After reset, every register is 0x00 except register 8 (0x0F), register 6, register 7 and the strap nibble of register 1. SDA is released.
- R11: A STOP returns the block to idle with SDA released. A START at any point, even in the middle of a byte, restarts address reception.
- R12: The block begins pulling SDA low only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap_i | input | 4 | Strap pin levels captured after reset into register 1 bits 3:0 |
| cfg_o | output | NUM_REGS*8 | All register values, register k at bits k*8+7:k*8 |

## Verification
Each pin change reaches the state machine after two synchronizer flops, FILT_LEN filter cycles and one edge register, which is about six system clocks. The block's ACK, its data bits and its release of SDA therefore follow the filtered SCL fall by that many cycles. The bench holds every SCL quarter period for ten clocks and samples SDA in the middle of the high phase, so each slave-driven bit has long settled when it is read. A register write lands on cfg_o one clock after the filtered eighth SCL fall of its byte, and the bench compares cfg_o only after the STOP, once all writes have settled.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_RACK} phase_t;
  typedef enum logic [1:0] {RL_ADDR, RL_INDEX, RL_COUNT, RL_DATA} role_t;

  localparam logic [6:0] DEV_ADDR7 = 7'h69;
  localparam int IDX_STRAP = 1;
  localparam int IDX_VEND  = 6;
  localparam int IDX_DEVID = 7;
  localparam int IDX_COUNT = 8;

  // bits that a host write may change
  function automatic logic [7:0] wr_mask(int idx);
    if (idx == IDX_STRAP) return 8'hF0;
    if (idx == IDX_VEND || idx == IDX_DEVID) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] rst_val(int idx);
    return (idx == IDX_COUNT) ? 8'h0F : 8'h00;
  endfunction

  // read-only content merged into a register
  function automatic logic [7:0] fixed_bits(int idx, logic [3:0] strap, logic [3:0] rev);
    if (idx == IDX_STRAP) return {4'h0, strap};
    if (idx == IDX_VEND)  return {rev, 4'h1};
    if (idx == IDX_DEVID) return 8'h22;
    return 8'h00;
  endfunction
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN) + 1;
  logic [1:0]    meta;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 2'b11;
      cnt  <= '0;
      dout <= 1'b1;
    end else begin
      meta <= {meta[0], din};
      if (meta[1] != dout) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          dout <= meta[1];
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cx_regs.sv
module i2cx_regs
  import i2cx_pkg::*;
#(
  parameter int         NUM_REGS = 24,
  parameter logic [3:0] REV_ID   = 4'h0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_idx,
  input  logic [3:0]            strap_i,
  output logic [7:0]            rd_data,
  output logic                  strap_done,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic [3:0] strap_q;
  logic [7:0] view [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= 4'h0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_i;
      strap_done <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] WM = wr_mask(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= rst_val(g);
      else if (wr_en && wr_idx == 8'(g)) q <= (q & ~WM) | (wr_data & WM);
    end
    assign view[g] = (q & WM) | fixed_bits(g, strap_q, REV_ID);
    assign cfg_o[g*8 +: 8] = view[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == 8'(i)) rd_data = view[i];
  end
endmodule

// File: rtl/i2cx_slave.sv
module i2cx_slave
  import i2cx_pkg::*;
#(
  parameter int         NUM_REGS = 24,
  parameter int         FILT_LEN = 3,
  parameter logic [3:0] REV_ID   = 4'h0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [3:0]            strap_i,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic scl_f, sda_f, scl_d, sda_d;

  i2cx_sync #(.FILT_LEN(FILT_LEN)) u_scl (.clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
  i2cx_sync #(.FILT_LEN(FILT_LEN)) u_sda (.clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  // named bus events
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

  phase_t     phase;
  role_t      role;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh, ptr, remain;
  logic [6:0] tx_sh;
  logic       rd_mode, nack_q;

  logic       byte_done, addr_hit, wr_fire, strap_done;
  logic [7:0] rd_idx, rd_data;

  assign byte_done = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = (rx_sh[7:1] == DEV_ADDR7);
  assign wr_fire   = byte_done && (role == RL_DATA) && (remain != 8'h00);
  assign rd_idx    = (phase == PH_ACK) ? 8'(IDX_COUNT) : ptr;

  i2cx_regs #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_idx(ptr), .wr_data(rx_sh),
    .rd_idx(rd_idx), .strap_i(strap_i), .rd_data(rd_data),
    .strap_done(strap_done), .cfg_o(cfg_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      role    <= RL_ADDR;
      bitcnt  <= 4'd0;
      rx_sh   <= 8'h00;
      tx_sh   <= 7'h00;
      ptr     <= 8'h00;
      remain  <= 8'h00;
      rd_mode <= 1'b0;
      nack_q  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      phase  <= PH_RX;
      role   <= RL_ADDR;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            rx_sh  <= {rx_sh[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            phase  <= PH_ACK;
            sda_oe <= 1'b1;
            unique case (role)
              RL_ADDR: begin
                if (addr_hit) begin
                  rd_mode <= rx_sh[0];
                  role    <= RL_INDEX;
                end else begin
                  phase  <= PH_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              RL_INDEX: begin
                ptr  <= rx_sh;
                role <= RL_COUNT;
              end
              RL_COUNT: begin
                remain <= rx_sh;
                role   <= RL_DATA;
              end
              RL_DATA: begin
                if (remain != 8'h00) begin
                  ptr    <= ptr + 8'd1;
                  remain <= remain - 8'd1;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt <= 4'd0;
            if (rd_mode) begin
              tx_sh  <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_RACK;
            end else begin
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[5:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        PH_RACK: begin
          if (scl_rise) nack_q <= sda_f;
          if (scl_fall) begin
            if (nack_q) begin
              phase <= PH_IDLE;
            end else begin
              tx_sh  <= rd_data[6:0];
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 8'd1;
              bitcnt <= 4'd0;
              phase  <= PH_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cx_chk.sv
module i2cx_chk
  import i2cx_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_f,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg_o,
  input phase_t                phase,
  input logic [3:0]            bitcnt,
  input logic                  start_ev,
  input logic                  stop_ev,
  input logic                  wr_fire,
  input logic [7:0]            ptr,
  input logic                  strap_done,
  input logic                  byte_done,
  input role_t                 role,
  input logic                  addr_hit
);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  p_bad_addr_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && role == RL_ADDR && !addr_hit) |=> (phase == PH_IDLE && !sda_oe));

  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (phase == PH_IDLE && !sda_oe));

  p_start_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (phase == PH_RX && bitcnt == 4'd0));

  p_oob_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ptr >= NREG8) |=> $stable(cfg_o));

  p_devid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[IDX_DEVID*8 +: 8] == 8'h22);

  p_strap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(cfg_o[IDX_STRAP*8 +: 4]));
endmodule

bind i2cx_slave i2cx_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe), .cfg_o(cfg_o),
  .phase(phase), .bitcnt(bitcnt), .start_ev(start_ev), .stop_ev(stop_ev),
  .wr_fire(wr_fire), .ptr(ptr), .strap_done(strap_done), .byte_done(byte_done),
  .role(role), .addr_hit(addr_hit));

// File: tb/sim_i2cx_slave.sv
module sim_i2cx_slave;
  localparam int NR = 24;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] strap = 4'hA;
  logic sda_oe;
  logic [NR*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int errors = 0;
  int checks = 0;
  int r12_viol = 0;
  logic [7:0] m [NR];

  always #2 clk = ~clk;

  i2cx_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
                 .sda_oe(sda_oe), .strap_i(strap), .cfg_o(cfg));

  // R12 monitor: slave may only start pulling while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) r12_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wm(int i);
    if (i == 1) return 8'hF0;
    if (i == 6 || i == 7) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic string tag_of(int i);
    if (i == 1) return "R8";
    if (i == 6 || i == 7) return "R7";
    if (i == 8) return "R6";
    return "R2";
  endfunction

  function automatic logic [7:0] mrd(int i);
    return (i < NR) ? m[i] : 8'h00;
  endfunction

  task automatic mwr(int i, logic [7:0] d);
    if (i < NR) m[i] = (m[i] & ~wm(i)) | (d & wm(i));
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic wbit(logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); b = sda_line;
    qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic wbyte(logic [7:0] d, output logic ack);
    logic b;
    for (int k = 7; k >= 0; k--) wbit(d[k]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(logic give_ack, output logic [7:0] d);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      rbit(b);
      d[k] = b;
    end
    wbit(~give_ack);
  endtask

  task automatic cmp_all(string why);
    for (int i = 0; i < NR; i++)
      chk($sformatf("%s/%s reg%0d", tag_of(i), why, i), cfg[i*8 +: 8], m[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    for (int i = 0; i < NR; i++) m[i] = 8'h00;
    m[1] = 8'h0A; m[6] = 8'h01; m[7] = 8'h22; m[8] = 8'h0F;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap = 4'h3;  // R8: later strap changes must not show
    repeat (20) @(negedge clk);
    cmp_all("R10 reset");
    chk("R10 sda released", sda_oe, 0);

    // R1: foreign address is NACKed and the rest ignored
    i2c_start();
    wbyte(8'hA0, a); chk("R1 foreign addr nack", a, 0);
    wbyte(8'h02, a); wbyte(8'h01, a); wbyte(8'h55, a);
    chk("R1 bytes after nack ignored", a, 0);
    i2c_stop();
    repeat (20) @(negedge clk);
    chk("R1 reg2 untouched", cfg[2*8 +: 8], 8'h00);

    // R2/R9: block write of 26 bytes from index 0
    i2c_start();
    wbyte(8'hD2, a); chk("R1 write addr ack", a, 1);
    wbyte(8'h00, a); chk("R2 index ack", a, 1);
    wbyte(8'd26, a); chk("R2 count ack", a, 1);
    for (int i = 0; i < 26; i++) begin
      v = 8'((i * 37 + 5) & 255);
      wbyte(v, a);
      chk(i < NR ? "R2 data ack" : "R9 oob data ack", a, 1);
      mwr(i, v);
    end
    i2c_stop();
    repeat (20) @(negedge clk);
    cmp_all("block write");
    chk("R12 no drive start while scl high", r12_viol, 0);

    // R3: byte after count is exhausted
    i2c_start();
    wbyte(8'hD2, a); wbyte(8'h03, a); wbyte(8'h01, a);
    wbyte(8'hC3, a); chk("R2 data ack", a, 1); mwr(3, 8'hC3);
    wbyte(8'h3C, a); chk("R3 extra byte ack", a, 1);
    i2c_stop();
    repeat (20) @(negedge clk);
    chk("R3 reg3 stored", cfg[3*8 +: 8], m[3]);
    chk("R3 reg4 untouched", cfg[4*8 +: 8], m[4]);

    // R4/R9/R5: read 28 registers from index 0
    i2c_start();
    wbyte(8'hD2, a); wbyte(8'h00, a);
    i2c_start();
    wbyte(8'hD3, a); chk("R1 read addr ack", a, 1);
    rbyte(1'b1, v); chk("R4 count byte first", v, m[8]);
    for (int i = 0; i < 28; i++) begin
      rbyte(i != 27, v);
      chk(i < NR ? "R4 read data" : "R9 oob reads zero", v, mrd(i));
    end
    repeat (20) @(negedge clk);
    chk("R5 released after nack", sda_oe, 0);
    i2c_stop();

    // R6: count register rewritten, later read returns it first
    i2c_start();
    wbyte(8'hD2, a); wbyte(8'h08, a); wbyte(8'h01, a); wbyte(8'h05, a);
    i2c_stop(); mwr(8, 8'h05);
    i2c_start();
    wbyte(8'hD2, a); wbyte(8'h08, a);
    i2c_start();
    wbyte(8'hD3, a);
    rbyte(1'b1, v); chk("R6 new count returned", v, 8'h05);
    rbyte(1'b0, v); chk("R6 reg8 readback", v, 8'h05);
    i2c_stop();

    // R9: write at index 30 is ACKed and ignored
    i2c_start();
    wbyte(8'hD2, a); wbyte(8'd30, a); wbyte(8'h02, a);
    wbyte(8'hEE, a); chk("R9 oob write ack", a, 1);
    wbyte(8'hDD, a); chk("R9 oob write ack", a, 1);
    i2c_stop();

    // R11: START in the middle of a byte restarts addressing
    i2c_start();
    wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    i2c_start();
    wbyte(8'hD2, a); chk("R11 restart addr ack", a, 1);
    wbyte(8'h05, a); wbyte(8'h01, a); wbyte(8'h77, a); mwr(5, 8'h77);
    i2c_stop();
    repeat (20) @(negedge clk);
    chk("R11 idle after stop", sda_oe, 0);
    cmp_all("final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule